// File: doc/BRIEF.md
# Pairwise Tree Reduction Adder

This block adds up an array of unsigned values that is spread across a row of processing lanes, each lane holding two operands. When a run is started, every lane adds its own pair of operands in the same clock. After that the lanes combine their partial sums in a binary tree. In each clock, half of the lanes that still hold a partial sum pass it to a partner lane, which adds it to its own. The number of lanes that still hold a sum halves on every step until only lane 0 is left, and lane 0 then holds the grand total.

For LANES lanes (a power of two, at least 2), a run of 2×LANES operands takes log2(LANES)+1 steps of one clock each. A serial adder would need 2×LANES−1 additions for the same array. Partial sums grow by one bit per tree level, so the result can never overflow. The block exposes its step counter so that the latency of a run can be checked from outside. The result stays on the output until a later run finishes.

Top module: `tree_sum_reducer`

## Requirements
- R1: While reset is low, and in the first cycle after reset is released, `busy`, `done`, `total` and `steps` are all zero.
- R2: A `start` sampled high while `busy` is low begins a run. `busy` goes high at that clock edge and stays high for exactly log2(LANES) cycles.
- R3: When a run completes, `total` equals the exact unsigned sum of all 2×LANES operands captured at the accepted start. This holds even when every operand is at its maximum value 2^W−1. Operand j sits in bits [j*W +: W] of `operands`, and lane i holds operands 2i and 2i+1.
- R4: `done` is a single-cycle pulse. It is high in the cycle right after the final combining edge, which is the same edge at which `busy` falls.
- R5: `steps` becomes 1 at the edge that accepts a start and then goes up by 1 on each clock of the run. It reaches log2(LANES)+1 when `done` is high and holds that value until the next accepted start.
- R6: While `busy` is high, `start` is ignored. Changes to `operands` during a run also have no effect on that run's `total`.
- R7: `total` changes only at the edge that raises `done`. Between runs, and during a run that has not yet finished, it keeps the previous result.
- R8: A `start` given in the cycle in which `done` is high is accepted, because `busy` is already low in that cycle. `busy` is then high and `steps` is 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to begin a run; accepted only when the block is idle |
| operands | input | 2*LANES*W | Parallel load of the array; operand j in bits [j*W +: W] |
| busy | output | 1 | High while combining steps are still to come |
| done | output | 1 | One-cycle pulse when the total becomes valid |
| total | output | W+log2(LANES)+1 | Sum of the most recently completed run |
| steps | output | clog2(log2(LANES)+2) | Number of steps taken in the current or last run |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before any run starts. They also assume that `start` and `operands` are stable around the rising edge. Under these assumptions the step counter and the busy flag move together, and the total can only change on a done pulse. The stimulus changes every input on the falling edge and releases reset only after several edges. It also drives `start` high during busy cycles and in the done cycle on purpose, so the properties about ignored and back-to-back starts are exercised. Operands come from zero, all-ones, ascending and pseudo-random patterns, so both the upper bound on the sum and the tree ordering are covered.

// File: rtl/tsr_pkg.sv
// Package: shared definitions for the tree reduction adder.
// Assumes: nothing beyond being compiled before the modules that use it.
package tsr_pkg;

    // Width of a full sum of 2*lanes operands of w bits each (lanes is a power of two)
    function automatic int sum_width(input int w, input int lanes);
        return w + $clog2(lanes) + 1;
    endfunction

endpackage

// File: rtl/tsr_pair_fold.sv
// Module: adds the two local operands of one lane (this is the first step of a run).
// Assumes: the operands are unsigned; the output width is at least W+1 bits.
module tsr_pair_fold #(
    parameter int W  = 8,
    parameter int SW = 12
) (
    input  logic [W-1:0]  opnd_lo,
    input  logic [W-1:0]  opnd_hi,
    output logic [SW-1:0] pair_sum
);

    // Zero-extend both operands and add them
    always_comb begin
        pair_sum = SW'(opnd_lo) + SW'(opnd_hi);
    end

endmodule

// File: rtl/tsr_combine_level.sv
// Module: one tree level of partner additions, chosen by the level input.
// At level k, each lane whose index is a multiple of 2^k adds the sum held by
// lane index+2^(k-1). Every other lane keeps its value unchanged.
// Assumes: LANES is a power of two; level is in 1..log2(LANES) when it is used.
module tsr_combine_level #(
    parameter int LANES = 8,
    parameter int SW    = 12,
    parameter int LW    = 2
) (
    input  logic [LW-1:0]             level,
    input  logic [LANES-1:0][SW-1:0]  parts_in,
    output logic [LANES-1:0][SW-1:0]  parts_out
);

    localparam int LVLS = $clog2(LANES);

    // Pick the receiving lanes for the active level and add in their partners
    always_comb begin
        parts_out = parts_in;
        for (int k = 1; k <= LVLS; k++) begin
            if (level == LW'(k)) begin
                for (int i = 0; i < LANES; i += (1 << k)) begin
                    parts_out[i] = parts_in[i] + parts_in[i + (1 << (k - 1))];
                end
            end
        end
    end

endmodule

// File: rtl/tsr_step_ctrl.sv
// Module: run sequencing for the reduction. It accepts a start when idle,
// steps through the tree levels one per clock, and raises done after the last one.
// Assumes: LVLS >= 1. The step count includes the local fold step.
module tsr_step_ctrl #(
    parameter int LVLS = 3,
    parameter int LW   = 2,
    parameter int STW  = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    output logic           accept,
    output logic           last,
    output logic [LW-1:0]  level,
    output logic           busy,
    output logic           done,
    output logic [STW-1:0] steps
);

    // Decode the accept and final-level conditions
    always_comb begin
        accept = start && !busy;
        last   = busy && (level == LW'(LVLS));
    end

    // Advance the level and step count; raise done for one cycle at the end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            level <= '0;
            steps <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy  <= 1'b1;
                level <= LW'(1);
                steps <= STW'(1);
            end else if (busy) begin
                level <= level + LW'(1);
                steps <= steps + STW'(1);
                if (last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/tree_sum_reducer.sv
// Module: top of the pairwise tree reduction adder. Lane i holds operands 2i and 2i+1.
// Each lane folds its pair at start, then the log2(LANES) levels of partner
// additions follow, one per clock, and the total is registered from lane 0.
// Assumes: LANES is a power of two and at least 2; operands are unsigned.
module tree_sum_reducer #(
    parameter int LANES = 8,
    parameter int W     = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   start,
    input  logic [2*LANES*W-1:0]                   operands,
    output logic                                   busy,
    output logic                                   done,
    output logic [W+$clog2(LANES):0]               total,
    output logic [$clog2($clog2(LANES)+2)-1:0]     steps
);

    localparam int LVLS = $clog2(LANES);
    localparam int SW   = tsr_pkg::sum_width(W, LANES);
    localparam int LW   = $clog2(LVLS + 1);
    localparam int STW  = $clog2(LVLS + 2);

    logic                      accept;
    logic                      last;
    logic [LW-1:0]             level;
    logic [LANES-1:0][SW-1:0]  folded;
    logic [LANES-1:0][SW-1:0]  partial;
    logic [LANES-1:0][SW-1:0]  combined;

    tsr_step_ctrl #(.LVLS(LVLS), .LW(LW), .STW(STW)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .accept (accept),
        .last   (last),
        .level  (level),
        .busy   (busy),
        .done   (done),
        .steps  (steps)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        tsr_pair_fold #(.W(W), .SW(SW)) u_fold (
            .opnd_lo  (operands[(2*g)*W +: W]),
            .opnd_hi  (operands[(2*g+1)*W +: W]),
            .pair_sum (folded[g])
        );
    end

    tsr_combine_level #(.LANES(LANES), .SW(SW), .LW(LW)) u_comb (
        .level     (level),
        .parts_in  (partial),
        .parts_out (combined)
    );

    // Lane partial sums: loaded by the fold step, then updated by each tree level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            partial <= '0;
        end else if (accept) begin
            partial <= folded;
        end else if (busy) begin
            partial <= combined;
        end
    end

    // Result register: takes lane 0 at the final level and then holds it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            total <= '0;
        end else if (last) begin
            total <= combined[0];
        end
    end

endmodule

// File: rtl/tree_sum_reducer_chk.sv
// Module: property checker for tree_sum_reducer, attached to it by bind.
// Assumes: reset is applied before the first run.
module tree_sum_reducer_chk #(
    parameter int LANES = 8,
    parameter int W     = 8
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                start,
    input logic                                busy,
    input logic                                done,
    input logic [W+$clog2(LANES):0]            total,
    input logic [$clog2($clog2(LANES)+2)-1:0]  steps
);

    localparam int LVLS = $clog2(LANES);
    localparam int SW   = W + LVLS + 1;
    localparam int STW  = $clog2(LVLS + 2);
    localparam logic [SW-1:0] MAXSUM = SW'(2 * LANES * ((1 << W) - 1));

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_busy_fall_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_steps_final_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> steps == STW'(LVLS + 1));

    p_steps_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> steps == $past(steps) + STW'(1));

    p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> steps != STW'(1));

    p_total_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(total) |-> done);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> total <= MAXSUM);

endmodule

bind tree_sum_reducer tree_sum_reducer_chk #(.LANES(LANES), .W(W)) u_chk (.*);

// File: tb/tree_sum_reducer_tb.sv
module tree_sum_reducer_tb;

    localparam int LANES = 8;
    localparam int W     = 8;
    localparam int LVLS  = $clog2(LANES);
    localparam int SW    = W + LVLS + 1;
    localparam int STW   = $clog2(LVLS + 2);
    localparam int N     = 2 * LANES;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic [N*W-1:0]       operands = '0;
    logic                 busy;
    logic                 done;
    logic [SW-1:0]        total;
    logic [STW-1:0]       steps;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Behavioural model state
    int m_busy = 0, m_done = 0, m_total = 0, m_steps = 0, m_acc = 0;

    always #5 clk = ~clk;

    tree_sum_reducer #(.LANES(LANES), .W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .operands(operands),
        .busy(busy), .done(done), .total(total), .steps(steps)
    );

    function automatic int array_sum(input logic [N*W-1:0] v);
        int s = 0;
        for (int j = 0; j < N; j++) s += int'(v[j*W +: W]);
        return s;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: advances one clock at a time from the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_total = 0; m_steps = 0;
        end else begin
            m_done = 0;
            if (start && m_busy == 0) begin
                m_acc = array_sum(operands);
                m_busy = 1;
                m_steps = 1;
            end else if (m_busy != 0) begin
                m_steps++;
                if (m_steps == LVLS + 1) begin
                    m_busy = 0;
                    m_done = 1;
                    m_total = m_acc;
                end
            end
        end
    end

    // Compare every output against the model on each falling edge
    always @(negedge clk) begin
        if (!finished) begin
            check(busy == m_busy[0], "R2 busy", int'(busy), m_busy);
            check(done == m_done[0], "R4 done", int'(done), m_done);
            check(int'(total) == m_total, "R3/R7 total", int'(total), m_total);
            check(int'(steps) == m_steps, "R5 steps", int'(steps), m_steps);
        end
    end

    task automatic wait_done();
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (done) return;
        end
    endtask

    task automatic run(input logic [N*W-1:0] v, input string tag);
        @(negedge clk);
        operands = v;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check(int'(total) == array_sum(v), tag, int'(total), array_sum(v));
    endtask

    initial begin
        logic [N*W-1:0] v;
        logic [N*W-1:0] first;
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && total == 0 && steps == 0, "R1 reset state",
              int'(total) + int'(steps), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && total == 0 && steps == 0, "R1 after release", int'(steps), 0);

        run('0, "R3 zeros");
        run('1, "R3 all max no overflow");
        for (int j = 0; j < N; j++) v[j*W +: W] = W'(j + 1);
        run(v, "R3 ascending");
        for (int r = 0; r < 3; r++) begin
            for (int j = 0; j < N; j++) v[j*W +: W] = W'($urandom);
            run(v, "R3 random");
        end

        // R6: start and operand changes during a run are ignored
        for (int j = 0; j < N; j++) first[j*W +: W] = W'(3 * j + 7);
        @(negedge clk);
        operands = first;
        start = 1'b1;
        @(negedge clk);
        operands = '1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check(int'(total) == array_sum(first), "R6 ignored start/operands",
              int'(total), array_sum(first));

        // R8: start in the done cycle is accepted; R7: old total held meanwhile
        for (int j = 0; j < N; j++) v[j*W +: W] = W'(200 - j);
        operands = v;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1 && steps == STW'(1), "R8 start on done cycle",
              int'(steps), 1);
        check(int'(total) == array_sum(first), "R7 total held during run",
              int'(total), array_sum(first));
        wait_done();
        repeat (5) @(negedge clk);
        check(int'(total) == array_sum(v), "R7 total held after run",
              int'(total), array_sum(v));
        check(int'(steps) == LVLS + 1, "R5 steps held after run", int'(steps), LVLS + 1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual=hung expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule